// File: doc/BRIEF.md
# PCI Target Memory Write Responder

This block is the target-side control for memory write cycles on a 64-bit capable PCI bus. It watches for the start of a transaction and decodes the address against one programmable memory window. It accepts only memory write commands. When it accepts a cycle, it enables its bus drivers on the next clock and claims the cycle by asserting the device-select line. If the master asked for a 64-bit transfer, it also asserts the 64-bit acknowledge.

Once the cycle is claimed, the block accepts one or more data phases. A data phase completes on a clock edge where both the master-ready and target-ready lines are low. The target-ready line follows the readiness of a simple local write port. Each completed phase hands the current address, data and active-high byte enables to that port. The address then advances by the transfer width.

A master that did not request 64 bits gets a 32-bit transfer. In that case only the low half of the data and byte enables is passed on. After the last phase, the block drives its control lines high for one clock and then releases all of its drivers.

Top module: `pci_memwr_target`

## Requirements
- R1: When the clock edge that first samples frame_n low (after a clock with it high, with no cycle in progress) also sees a memory write command and a decode hit, tgt_oe is high and devsel_n low from the following clock on. The memory write commands are cbe[3:0] = 4'b0111 and 4'b1111.
- R2: An address phase with a decode miss, or with any other command, leaves tgt_oe, wide_oe and wr_valid low for the whole transaction.
- R3: ack64_n goes low and wide_oe high only on a claimed cycle whose address phase sampled req64_n low. In a 32-bit claimed cycle, ack64_n stays high and wide_oe stays low.
- R4: While a cycle is claimed, trdy_n is low exactly when wr_ready is high. A data phase completes only on an edge where irdy_n and trdy_n are both low. A wait (wr_ready low) leaves wr_addr unchanged.
- R5: In a claimed data state with irdy_n low, wr_valid is high. wr_addr, wr_data and wr_be then show the current phase, and wr_be is the bitwise inverse of the bus byte enables.
- R6: After each completed phase that is not the last, wr_addr advances by 8 in a 64-bit cycle and by 4 in a 32-bit cycle.
- R7: In a 32-bit cycle, wr_data[63:32] and wr_be[7:4] are zero, whatever is on the upper bus half.
- R8: A phase that completes with frame_n high is the last one. On the next clock devsel_n, trdy_n and ack64_n are high with tgt_oe still high. One clock later tgt_oe and wide_oe are low.
- R9: The decode compares only address bits [31:BAR_LOG2] with bar_base. An address that differs from bar_base only in the lower bits still hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bar_base | input | 32 | Window base, aligned to 2**BAR_LOG2 |
| frame_n | input | 1 | Cycle frame, active low |
| irdy_n | input | 1 | Master ready, active low |
| req64_n | input | 1 | 64-bit request, active low |
| ad | input | 64 | Address/data bus as sampled |
| cbe_n | input | 8 | Command/byte enables as sampled, active low |
| devsel_n | output | 1 | Device select value |
| trdy_n | output | 1 | Target ready value |
| stop_n | output | 1 | Stop value (always high) |
| ack64_n | output | 1 | 64-bit acknowledge value |
| tgt_oe | output | 1 | Enable for ad, devsel, trdy, stop and parity drivers |
| wide_oe | output | 1 | Enable for 64-bit acknowledge and upper parity drivers |
| wr_valid | output | 1 | Local write phase presented |
| wr_ready | input | 1 | Local side can take a write |
| wr_addr | output | 32 | Byte address of the current phase |
| wr_data | output | 64 | Write data |
| wr_be | output | 8 | Byte enables, active high |

## Verification
A claim flag stuck in the wrong state shows at the ports one clock after the address phase. Either tgt_oe and devsel_n fail to move, or they move on a miss. A wrong width flag shows at once as ack64_n or wide_oe at the wrong level, and as upper data leaking through in 32-bit cycles. A bad address counter stays hidden until the second phase of a burst, when wr_addr is off by the step. A turnaround state that is skipped or held too long shows as tgt_oe changing one clock early or late after the last phase.

// File: rtl/pci_tw_pkg.sv
// Package: shared types and command codes for the PCI memory write target.
// Assumes bus command values as sampled on cbe[3:0] in the address phase.
package pci_tw_pkg;

    typedef enum logic [1:0] {
        TW_IDLE = 2'd0,
        TW_DATA = 2'd1,
        TW_TURN = 2'd2
    } tw_state_e;

    localparam logic [3:0] CMD_MEM_WR     = 4'b0111;
    localparam logic [3:0] CMD_MEM_WR_INV = 4'b1111;

    // True for the two memory write command codes.
    function automatic logic is_mem_write(input logic [3:0] cmd);
        return (cmd == CMD_MEM_WR) || (cmd == CMD_MEM_WR_INV);
    endfunction

endpackage

// File: rtl/tw_bar_decode.sv
// Module: combinational window and command decode for the address phase.
// Assumes bar_base is aligned to 2**BAR_LOG2; its low bits are ignored.
module tw_bar_decode #(
    parameter int ADDR_W   = 32,
    parameter int BAR_LOG2 = 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        cmd,
    input  logic [ADDR_W-1:0] bar_base,
    output logic              claim
);
    import pci_tw_pkg::*;

    localparam int TAG_W = ADDR_W - BAR_LOG2;

    logic [TAG_W-1:0] addr_tag;
    logic [TAG_W-1:0] base_tag;

    // Select the upper address bits that identify the window.
    always_comb begin
        addr_tag = addr[ADDR_W-1:BAR_LOG2];
        base_tag = bar_base[ADDR_W-1:BAR_LOG2];
    end

    // Claim only memory writes that land in the window.
    always_comb begin
        claim = (addr_tag == base_tag) && is_mem_write(cmd);
    end

endmodule

// File: rtl/tw_burst_addr.sv
// Module: burst address counter for the local write port.
// Assumes load and step are never high in the same cycle.
module tw_burst_addr #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    input  logic              wide,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] STEP_WIDE   = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] STEP_NARROW = ADDR_W'(4);

    // Load on claim, advance by transfer width on each completed phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_addr;
        end else if (step) begin
            addr <= addr + (wide ? STEP_WIDE : STEP_NARROW);
        end
    end

endmodule

// File: rtl/tw_phase_ctrl.sv
// Module: transaction state machine; owns claim, width and driver enables.
// Assumes frame_n, irdy_n and req64_n are sampled synchronously to clk.
module tw_phase_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n,
    input  logic irdy_n,
    input  logic req64_n,
    input  logic hit,
    input  logic wr_ready,
    output logic load,
    output logic fire,
    output logic wide,
    output logic in_data,
    output logic devsel_n,
    output logic trdy_n,
    output logic ack64_n,
    output logic tgt_oe,
    output logic wide_oe
);
    import pci_tw_pkg::*;

    tw_state_e state_q;
    tw_state_e state_d;
    logic      frame_q;
    logic      addr_phase;

    // Remember last sampled frame_n to find the first address clock.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_q <= 1'b1;
        else        frame_q <= frame_n;
    end

    // Address phase: frame newly asserted while no cycle is in progress.
    always_comb begin
        addr_phase = (state_q == TW_IDLE) && !frame_n && frame_q;
        load       = addr_phase && hit;
        in_data    = (state_q == TW_DATA);
        fire       = in_data && wr_ready && !irdy_n;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TW_IDLE: if (load)              state_d = TW_DATA;
            TW_DATA: if (fire && frame_n)   state_d = TW_TURN;
            TW_TURN:                        state_d = TW_IDLE;
            default:                        state_d = TW_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TW_IDLE;
        else        state_q <= state_d;
    end

    // Width flag captured from req64_n in the address phase.
    always_ff @(posedge clk) begin
        if (!rst_n)    wide <= 1'b0;
        else if (load) wide <= !req64_n;
    end

    // Registered control line values and driver enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            devsel_n <= 1'b1;
            ack64_n  <= 1'b1;
            tgt_oe   <= 1'b0;
            wide_oe  <= 1'b0;
        end else begin
            unique case (state_d)
                TW_DATA: begin
                    devsel_n <= 1'b0;
                    ack64_n  <= load ? req64_n : ack64_n;
                    tgt_oe   <= 1'b1;
                    wide_oe  <= load ? !req64_n : wide_oe;
                end
                TW_TURN: begin
                    devsel_n <= 1'b1;
                    ack64_n  <= 1'b1;
                    tgt_oe   <= 1'b1;
                end
                default: begin
                    devsel_n <= 1'b1;
                    ack64_n  <= 1'b1;
                    tgt_oe   <= 1'b0;
                    wide_oe  <= 1'b0;
                end
            endcase
        end
    end

    // Target ready tracks the local port while in the data state.
    always_comb begin
        trdy_n = !(in_data && wr_ready);
    end

endmodule

// File: rtl/pci_memwr_target.sv
// Module: top of the PCI memory write target. Decodes the address phase,
// claims hits, negotiates 64-bit width and feeds a local write port.
// Assumes bus inputs are already sampled; tri-state pads sit outside.
module pci_memwr_target #(
    parameter int BAR_LOG2 = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] bar_base,
    input  logic        frame_n,
    input  logic        irdy_n,
    input  logic        req64_n,
    input  logic [63:0] ad,
    input  logic [7:0]  cbe_n,
    output logic        devsel_n,
    output logic        trdy_n,
    output logic        stop_n,
    output logic        ack64_n,
    output logic        tgt_oe,
    output logic        wide_oe,
    output logic        wr_valid,
    input  logic        wr_ready,
    output logic [31:0] wr_addr,
    output logic [63:0] wr_data,
    output logic [7:0]  wr_be
);
    localparam int ADDR_W = 32;
    localparam int HALF_W = 32;
    localparam int LANE_N = 4;

    logic hit;
    logic load;
    logic fire;
    logic wide;
    logic in_data;

    tw_bar_decode #(
        .ADDR_W   (ADDR_W),
        .BAR_LOG2 (BAR_LOG2)
    ) u_dec (
        .addr     (ad[ADDR_W-1:0]),
        .cmd      (cbe_n[3:0]),
        .bar_base (bar_base),
        .claim    (hit)
    );

    tw_phase_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_n  (frame_n),
        .irdy_n   (irdy_n),
        .req64_n  (req64_n),
        .hit      (hit),
        .wr_ready (wr_ready),
        .load     (load),
        .fire     (fire),
        .wide     (wide),
        .in_data  (in_data),
        .devsel_n (devsel_n),
        .trdy_n   (trdy_n),
        .ack64_n  (ack64_n),
        .tgt_oe   (tgt_oe),
        .wide_oe  (wide_oe)
    );

    tw_burst_addr #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_addr (ad[ADDR_W-1:0]),
        .step      (fire),
        .wide      (wide),
        .addr      (wr_addr)
    );

    // Stop is never used for writes in this block.
    always_comb begin
        stop_n = 1'b1;
    end

    // Present a phase to the local side while the master has data.
    always_comb begin
        wr_valid = in_data && !irdy_n;
    end

    // Lane gating: the upper half passes only in 64-bit cycles.
    always_comb begin
        wr_data[HALF_W-1:0] = ad[HALF_W-1:0];
        wr_data[63:HALF_W]  = wide ? ad[63:HALF_W] : '0;
        wr_be[LANE_N-1:0]   = ~cbe_n[LANE_N-1:0];
        wr_be[7:LANE_N]     = wide ? ~cbe_n[7:LANE_N] : '0;
    end

endmodule

// File: rtl/pci_memwr_target_chk.sv
// Module: assertion checker bound to pci_memwr_target; observes ports only.
module pci_memwr_target_chk #(
    parameter int BAR_LOG2 = 12
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] bar_base,
    input logic        frame_n,
    input logic        irdy_n,
    input logic        req64_n,
    input logic [63:0] ad,
    input logic [7:0]  cbe_n,
    input logic        devsel_n,
    input logic        trdy_n,
    input logic        ack64_n,
    input logic        tgt_oe,
    input logic        wide_oe,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic [31:0] wr_addr,
    input logic [63:0] wr_data,
    input logic [7:0]  wr_be
);
    logic exp_hit;

    // Independent expectation of a claimable address phase.
    always_comb begin
        exp_hit = (ad[31:BAR_LOG2] == bar_base[31:BAR_LOG2]) &&
                  ((cbe_n[3:0] == 4'b0111) || (cbe_n[3:0] == 4'b1111));
    end

    a_r1_claim_next: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_n) && !tgt_oe && exp_hit |=> tgt_oe && !devsel_n);

    a_r2_no_write_unclaimed: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_oe |-> !wr_valid);

    a_r3_ack_needs_claim: assert property (@(posedge clk) disable iff (!rst_n)
        !ack64_n |-> !devsel_n && wide_oe && tgt_oe);

    a_r4_trdy_follows_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> wr_ready && tgt_oe && !devsel_n);

    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready && !frame_n |=>
        wr_addr == $past(wr_addr) + ($past(ack64_n) ? 32'd4 : 32'd8));

    a_r7_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && ack64_n |-> wr_data[63:32] == 32'd0 && wr_be[7:4] == 4'd0);

    a_r8_release_after_turn: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_oe && devsel_n |=> !tgt_oe && !wide_oe);

endmodule

bind pci_memwr_target pci_memwr_target_chk #(.BAR_LOG2(BAR_LOG2)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bar_base (bar_base),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .req64_n  (req64_n),
    .ad       (ad),
    .cbe_n    (cbe_n),
    .devsel_n (devsel_n),
    .trdy_n   (trdy_n),
    .ack64_n  (ack64_n),
    .tgt_oe   (tgt_oe),
    .wide_oe  (wide_oe),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_be    (wr_be)
);

// File: tb/pci_memwr_target_tb.sv
// Directed bench for pci_memwr_target: one task per scenario.
module pci_memwr_target_tb;
    localparam int BAR_LOG2 = 12;
    localparam logic [31:0] BASE = 32'h4000_3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bar_base = BASE;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic        req64_n = 1'b1;
    logic [63:0] ad = '0;
    logic [7:0]  cbe_n = 8'hFF;
    logic        wr_ready = 1'b1;
    logic        devsel_n, trdy_n, stop_n, ack64_n, tgt_oe, wide_oe, wr_valid;
    logic [31:0] wr_addr;
    logic [63:0] wr_data;
    logic [7:0]  wr_be;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pci_memwr_target #(.BAR_LOG2(BAR_LOG2)) u_dut (
        .clk(clk), .rst_n(rst_n), .bar_base(bar_base), .frame_n(frame_n),
        .irdy_n(irdy_n), .req64_n(req64_n), .ad(ad), .cbe_n(cbe_n),
        .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
        .ack64_n(ack64_n), .tgt_oe(tgt_oe), .wide_oe(wide_oe),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] word(input int i);
        return {32'hA5A5_0000 + 32'(i), 32'h1234_0000 + 32'(i)};
    endfunction

    function automatic logic [7:0] ben(input int i);
        return 8'(i * 37 + 5);
    endfunction

    // Drive one write; checks claim, width, phases, stepping and release.
    // stall_at: phase index that first sees one wait cycle (-1 for none).
    task automatic do_write(input logic [31:0] a, input logic [3:0] cmd,
                            input bit wide, input int n, input bit claim,
                            input int stall_at, input string tag);
        logic [31:0] exp_a;
        exp_a = a;
        @(negedge clk);
        frame_n = 1'b0; req64_n = !wide; irdy_n = 1'b1;
        ad = {32'hDEAD_BEEF, a}; cbe_n = {4'h0, cmd}; wr_ready = 1'b1;
        #1 check("R1", {tag, " oe before claim"}, 64'(tgt_oe), 64'd0);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_n = (i == n - 1); req64_n = (i == n - 1) ? 1'b1 : !wide;
            irdy_n = 1'b0; ad = word(i); cbe_n = ~ben(i);
            wr_ready = (i != stall_at);
            #1;
            if (claim) begin
                check("R1", {tag, " devsel"}, 64'(devsel_n), 64'd0);
                check("R1", {tag, " tgt_oe"}, 64'(tgt_oe), 64'd1);
                check("R3", {tag, " ack64_n"}, 64'(ack64_n), 64'(!wide));
                check("R3", {tag, " wide_oe"}, 64'(wide_oe), 64'(wide));
                check("R5", {tag, " wr_valid"}, 64'(wr_valid), 64'd1);
                check("R6", {tag, " wr_addr"}, 64'(wr_addr), 64'(exp_a));
                check("R7", {tag, " wr_data"}, wr_data,
                      wide ? word(i) : {32'd0, word(i)[31:0]});
                check("R5", {tag, " wr_be"}, 64'(wr_be),
                      64'(wide ? ben(i) : {4'd0, ben(i)[3:0]}));
                if (i == stall_at) begin
                    check("R4", {tag, " trdy wait"}, 64'(trdy_n), 64'd1);
                    @(negedge clk);
                    wr_ready = 1'b1;
                    #1;
                    check("R4", {tag, " addr held"}, 64'(wr_addr), 64'(exp_a));
                end
                check("R4", {tag, " trdy"}, 64'(trdy_n), 64'd0);
                exp_a = exp_a + (wide ? 32'd8 : 32'd4);
            end else begin
                check("R2", {tag, " oe"}, 64'({tgt_oe, wide_oe, wr_valid}), 64'd0);
                check("R2", {tag, " devsel"}, 64'(devsel_n), 64'd1);
            end
        end
        @(negedge clk);
        irdy_n = 1'b1; frame_n = 1'b1; req64_n = 1'b1; cbe_n = 8'hFF;
        #1;
        if (claim) begin
            check("R8", {tag, " turn ctl"}, 64'({devsel_n, trdy_n, ack64_n}), 64'd7);
            check("R8", {tag, " turn oe"}, 64'(tgt_oe), 64'd1);
        end
        @(negedge clk);
        #1 check("R8", {tag, " released"}, 64'({tgt_oe, wide_oe}), 64'd0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        #1 check("R8", "reset oe", 64'({tgt_oe, wide_oe, wr_valid}), 64'd0);
        check("R8", "reset ctl", 64'({devsel_n, trdy_n, ack64_n, stop_n}), 64'hF);
    endtask

    task automatic t_single64();  do_write(BASE + 32'h10, 4'b0111, 1, 1, 1, -1, "single64"); endtask
    task automatic t_burst64();   do_write(BASE + 32'h40, 4'b0111, 1, 4, 1, -1, "burst64");  endtask
    task automatic t_burst32();   do_write(BASE + 32'h80, 4'b1111, 0, 4, 1, -1, "burst32");  endtask
    task automatic t_wait();      do_write(BASE + 32'h20, 4'b0111, 1, 3, 1, 1, "wait64");   endtask
    task automatic t_lowbits();   do_write(BASE + 32'hFF8, 4'b0111, 0, 2, 1, -1, "R9 low"); endtask
    task automatic t_miss();      do_write(BASE + 32'h1000, 4'b0111, 1, 2, 0, -1, "miss");  endtask
    task automatic t_badcmd();    do_write(BASE + 32'h10, 4'b0110, 1, 2, 0, -1, "read");    endtask

    // Watchdog: a hung run is counted as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single64();
        t_burst64();
        t_burst32();
        t_wait();
        t_lowbits();
        t_miss();
        t_badcmd();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule